// File: doc/BRIEF.md
# Prioritised Level Interrupt Router

This block gathers a parameterised set of level-type interrupt lines and routes them to a small number of processor contexts. Every line has a small priority value. Every context has its own enable mask, its own threshold, and its own claim/complete word. A context's request output stays high while at least one line that is pending and enabled for it has a priority strictly above its threshold.

Software takes an interrupt by reading the claim word of its context. The read returns the winning source ID, or 0 when nothing qualifies, because ID 0 is never a real source. The read also removes that source from the pending set. Writing the ID back to the same word ends the service. The source can then be sampled as pending again. All registers sit behind a 32-bit word port. A read answers on the clock after the request.

Top module: `intc_core`

## Requirements
- R1: After reset all priorities, enable bits and thresholds are 0, no source is pending, `irq_o` is all zero and every read returns 0.
- R2: The priority of source ID n (1..NSRC) is the word at byte address 4·n. It keeps 3 bits: bits 31:3 read as 0 and written upper bits are dropped. Address 0 (ID 0) always reads 0 and ignores writes.
- R3: The enable word of context c is at 0x2080 + 0x100·c. Source n is bit n of it. Bit 0 reads 0. Addresses that map to no register read 0.
- R4: The threshold of context c is at 0x201000 + 0x2000·c. It keeps 3 bits and reads back with bits 31:3 at 0.
- R5: `irq_o[c]` is high exactly when some pending source enabled for c has a priority strictly greater than threshold c. A threshold of 7 therefore blocks everything.
- R6: A source whose priority is 0 never raises `irq_o` and is never returned by a claim.
- R7: A read of the claim word at 0x201004 + 0x2000·c returns, one clock later, the highest-priority eligible ID for c. On a tie it returns the lowest ID, and it returns 0 when no ID is eligible. `reg_rdata` is 0 in any cycle that does not follow a read.
- R8: A claim that returns ID n clears n's pending bit. n stays not pending, even with its line held high, until a completion for n is accepted.
- R9: A write of ID n to the claim word of context c completes n only if n is enabled for c. Otherwise the write has no effect.
- R10: A line that is high at a clock edge, while its source is neither pending nor in service, becomes pending at that edge. `irq_o` reflects the change in the same cycle, with no further register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_i | input | NSRC | Level interrupt lines; bit k is source ID k+1 |
| reg_req | input | 1 | Register access strobe, one cycle per access |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address of the 32-bit word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read request, else 0 |
| irq_o | output | NCTX | Per-context interrupt request |

## Verification
The checker assumes that each access is a single-cycle strobe, that addresses are word aligned, and that no claim read falls in the same cycle as a write to the priority being read. The bench drives `reg_req` for exactly one clock per access and leaves an idle cycle between accesses. It changes `src_i` only at falling edges and only between accesses, so every sampled value and every claim result is set by one well-defined edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned PRIO_LIMIT  = 32'h0000_1000;
  localparam int unsigned EN_BASE     = 32'h0000_2080;
  localparam int unsigned EN_STRIDE   = 32'h0000_0100;
  localparam int unsigned CTX_BASE    = 32'h0020_1000;
  localparam int unsigned CTX_STRIDE  = 32'h0000_2000;
  localparam int unsigned CLAIM_OFS   = 32'h0000_0004;
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/intc_gateway.sv
module intc_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o
);
  logic pend_q, pend_d;
  logic busy_q, busy_d;

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    if (claim_i) begin
      pend_d = 1'b0;
      busy_d = 1'b1;
    end else begin
      if (done_i) busy_d = 1'b0;
      if (line_i && !pend_q && !busy_q) pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter #(
  parameter int NSRC = 31,
  parameter int PW   = 3,
  localparam int IDW = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0]         pend_i,
  input  logic [NSRC-1:0]         en_i,
  input  logic [NSRC-1:0][PW-1:0] prio_i,
  input  logic [PW-1:0]           thr_i,
  output logic [IDW-1:0]          win_id_o,
  output logic                    irq_o
);
  logic [PW-1:0] best_p;

  // Ascending scan with a strict compare keeps the lowest ID on ties.
  always_comb begin
    best_p   = '0;
    win_id_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_i[i] && en_i[i] && (prio_i[i] > thr_i) && (prio_i[i] > best_p)) begin
        best_p   = prio_i[i];
        win_id_o = IDW'(i + 1);
      end
    end
  end

  assign irq_o = (win_id_o != '0);
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PW     = 3,
  parameter int ADDR_W = 26,
  localparam int IDW   = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCTX-1:0]   irq_o
);
  logic                           rst_s_n;
  logic [NSRC-1:0][PW-1:0]        prio_q, prio_d;
  logic [NCTX-1:0][NSRC-1:0]      en_q, en_d;
  logic [NCTX-1:0][PW-1:0]        thr_q, thr_d;
  logic [31:0]                    rdata_q, rdata_d;
  logic [NSRC-1:0]                pend, claim_vec, done_vec;
  logic [NCTX-1:0][IDW-1:0]       win_id;
  logic [31:0]                    a;
  logic                           wr, rd;

  intc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n));

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    intc_gateway u_gw (
      .clk(clk), .rst_n(rst_s_n), .line_i(src_i[s]),
      .claim_i(claim_vec[s]), .done_i(done_vec[s]), .pend_o(pend[s])
    );
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    intc_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
      .pend_i(pend), .en_i(en_q[c]), .prio_i(prio_q), .thr_i(thr_q[c]),
      .win_id_o(win_id[c]), .irq_o(irq_o[c])
    );
  end

  assign a  = 32'(reg_addr);
  assign wr = reg_req && reg_we;
  assign rd = reg_req && !reg_we;

  // Address decode, register next state, claim and completion strobes.
  always_comb begin
    prio_d    = prio_q;
    en_d      = en_q;
    thr_d     = thr_q;
    rdata_d   = '0;
    claim_vec = '0;
    done_vec  = '0;
    if (a < PRIO_LIMIT) begin
      for (int i = 1; i <= NSRC; i++) begin
        if (32'(a[11:2]) == i) begin
          if (wr) prio_d[i-1] = reg_wdata[PW-1:0];
          if (rd) rdata_d = 32'(prio_q[i-1]);
        end
      end
    end
    for (int c = 0; c < NCTX; c++) begin
      for (int i = 0; i < NSRC; i++) begin
        if (a == EN_BASE + c * EN_STRIDE + ((i + 1) / 32) * 4) begin
          if (wr) en_d[c][i] = reg_wdata[(i + 1) % 32];
          if (rd) rdata_d[(i + 1) % 32] = en_q[c][i];
        end
      end
      if (a == CTX_BASE + c * CTX_STRIDE) begin
        if (wr) thr_d[c] = reg_wdata[PW-1:0];
        if (rd) rdata_d = 32'(thr_q[c]);
      end
      if (a == CTX_BASE + c * CTX_STRIDE + CLAIM_OFS) begin
        if (rd) begin
          rdata_d = 32'(win_id[c]);
          for (int i = 0; i < NSRC; i++)
            if (32'(win_id[c]) == i + 1) claim_vec[i] = 1'b1;
        end
        if (wr) begin
          for (int i = 0; i < NSRC; i++)
            if (reg_wdata == i + 1 && en_q[c][i]) done_vec[i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      prio_q  <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr) begin
        prio_q <= prio_d;
        en_q   <= en_d;
        thr_q  <= thr_d;
      end
      rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk
  import intc_pkg::*;
#(
  parameter int NSRC   = 31,
  parameter int NCTX   = 2,
  parameter int PW     = 3,
  parameter int ADDR_W = 26
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      reg_req,
  input logic                      reg_we,
  input logic [ADDR_W-1:0]         reg_addr,
  input logic [31:0]               reg_rdata,
  input logic [NCTX-1:0]           irq_o,
  input logic [NSRC-1:0]           pend,
  input logic [NSRC-1:0][PW-1:0]   prio,
  input logic [NCTX-1:0][PW-1:0]   thr
);
  logic          got_pend;
  logic [PW-1:0] got_prio;

  always_comb begin
    got_pend = 1'b0;
    got_prio = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (reg_rdata == i + 1) begin
        got_pend = pend[i];
        got_prio = prio[i];
      end
    end
  end

  assert_prio_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prio == '0) |-> (irq_o == '0));

  assert_idle_rdata_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_req && !reg_we) |-> (reg_rdata == '0));

  assert_prio_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_req && !reg_we && 32'(reg_addr) < PRIO_LIMIT) |-> (reg_rdata[31:PW] == '0));

  for (genvar c = 0; c < NCTX; c++) begin : g_c
    localparam int unsigned CLAIM_A = CTX_BASE + c * CTX_STRIDE + CLAIM_OFS;

    assert_thr_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (thr[c] == '1) |-> !irq_o[c]);

    assert_claim_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reg_req && !reg_we && 32'(reg_addr) == CLAIM_A) && reg_rdata != '0)
        |-> !got_pend);

    assert_claim_above_thr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reg_req && !reg_we && 32'(reg_addr) == CLAIM_A) && reg_rdata != '0)
        |-> (got_prio > $past(thr[c])));
  end
endmodule

bind intc_core intc_core_chk #(.NSRC(NSRC), .NCTX(NCTX), .PW(PW), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_s_n), .reg_req(reg_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq_o(irq_o),
  .pend(pend), .prio(prio_q), .thr(thr_q)
);

// File: tb/tb_intc_core.sv
`timescale 1ns/1ps
module tb_intc_core;
  localparam int NSRC = 31, NCTX = 2, ADDR_W = 26;

  logic              clk;
  logic              rst_n;
  logic [NSRC-1:0]   src_i;
  logic              reg_req, reg_we;
  logic [ADDR_W-1:0] reg_addr;
  logic [31:0]       reg_wdata, reg_rdata;
  logic [NCTX-1:0]   irq_o;

  int n_chk = 0, n_fail = 0;
  logic rd_issued;
  logic done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  intc_core #(.NSRC(NSRC), .NCTX(NCTX), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] a_prio(int id);  return 32'(4 * id); endfunction
  function automatic logic [31:0] a_en(int c);     return 32'h2080 + 32'(c) * 32'h100; endfunction
  function automatic logic [31:0] a_thr(int c);    return 32'h20_1000 + 32'(c) * 32'h2000; endfunction
  function automatic logic [31:0] a_claim(int c);  return a_thr(c) + 32'd4; endfunction

  always @(posedge clk) rd_issued <= reg_req && !reg_we;

  // Monitor: pops the expected read result queued by the driver.
  always @(negedge clk) begin
    if (rd_issued && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (reg_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: rdata actual %h expected %h", t, reg_rdata, e);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [31:0] a, logic [31:0] d);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(logic [31:0] a, logic [31:0] e, string t);
    @(negedge clk);
    reg_req = 1'b1; reg_we = 1'b0; reg_addr = ADDR_W'(a);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_req = 1'b0;
  endtask

  task automatic chk(logic [31:0] got, logic [31:0] e, string t);
    n_chk++;
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, got, e);
    end
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_i = '0; reg_req = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    chk(32'(irq_o), 0, "R1 irq");
    rd(a_prio(1), 0, "R1 prio");
    rd(a_en(0), 0, "R1 enable");
    rd(a_thr(0), 0, "R1 threshold");
    rd(a_claim(0), 0, "R1 claim");

    // R2 priority width and ID 0
    wr(a_prio(3), 32'hFFFF_FFFD);
    rd(a_prio(3), 5, "R2 priority truncated");
    wr(a_prio(0), 7);
    rd(a_prio(0), 0, "R2 id0");

    // R3 enable layout
    wr(a_en(0), 32'hFFFF_FFFF);
    rd(a_en(0), 32'hFFFF_FFFE, "R3 enable bit0");
    wr(a_en(1), 32'h0000_0020);
    rd(a_en(1), 32'h0000_0020, "R3 enable ctx1");
    rd(32'h0010_0000, 0, "R3 unmapped");

    // R4 threshold
    wr(a_thr(1), 32'hA);
    rd(a_thr(1), 2, "R4 threshold");

    wr(a_prio(5), 2);
    wr(a_prio(7), 5);

    // R6 zero priority
    src_i[8] = 1'b1;
    idle(2);
    chk(32'(irq_o), 0, "R6 irq");
    rd(a_claim(0), 0, "R6 claim");

    // R5 strict compare
    src_i[4] = 1'b1;
    idle(1);
    chk(32'(irq_o), 32'b01, "R5 equal to threshold");
    wr(a_thr(1), 1);
    chk(32'(irq_o), 32'b11, "R5 above threshold");
    wr(a_thr(0), 7);
    chk(32'(irq_o[0]), 0, "R5 threshold 7");
    wr(a_thr(0), 0);

    // R7 claim order, R8 clear
    src_i[2] = 1'b1;
    src_i[6] = 1'b1;
    idle(1);
    rd(a_claim(0), 3, "R7 tie lowest id");
    rd(a_claim(0), 7, "R7 second");
    rd(a_claim(0), 5, "R7 third");
    rd(a_claim(0), 0, "R7 empty");
    idle(3);
    chk(32'(irq_o), 0, "R8 lines high, not pending");

    // R9 completion
    wr(a_claim(1), 3);
    idle(3);
    chk(32'(irq_o), 0, "R9 ignored completion");
    wr(a_claim(0), 3);
    idle(1);
    chk(32'(irq_o[0]), 1, "R9 accepted completion");
    rd(a_claim(0), 3, "R9 reclaim");
    wr(a_claim(1), 5);
    idle(1);
    chk(32'(irq_o), 32'b11, "R9 completion ctx1");
    rd(a_claim(1), 5, "R9 claim ctx1");
    rd(a_claim(0), 0, "R8 all in service");

    // R10 sampling latency
    wr(a_prio(11), 1);
    src_i[10] = 1'b1;
    chk(32'(irq_o[0]), 0, "R10 before edge");
    idle(1);
    chk(32'(irq_o[0]), 1, "R10 after edge");
    rd(a_claim(0), 11, "R10 claim");

    idle(3);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule